// File: doc/BRIEF.md
# Serial Programming Command Responder

This block sits between a UART receiver and a UART transmitter and answers a small set of commands from a serial programming protocol. Three commands are understood: a synchronisation probe, a parameter query and a device-signature query. Each command ends with a terminator byte (0x20). The block sends no reply until it has received that terminator in the position where the command says it must be.

A reply is always framed. It starts with an in-sync marker (0x14) and ends with an OK marker (0x10), with any payload bytes between them. A command whose terminator slot holds any other byte gets the single not-in-sync byte (0x15) instead. The block then waits for a new opcode.

Bytes arrive on a valid/ready input and replies leave one byte per handshake on a valid/ready output. The input is held off while a reply is being sent. An upstream receiver that drops bytes therefore makes the block read a later byte as a terminator or an opcode, and it falls out of step with the host.

Top module: `prog_cmd_responder`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: The input bytes 0x30, 0x20 (sync) produce exactly the output bytes 0x14, 0x10. Sync commands sent back to back are each answered.
- R3: The bytes 0x41, code, 0x20 (get-parameter) produce 0x14, value, 0x10. Code 0x80 yields value 0x03.
- R4: A get-parameter request whose code is not in the parameter table yields value 0x00 inside the normal 0x14 … 0x10 frame.
- R5: The bytes 0x75, 0x20 (read-signature) produce 0x14, 0x1E, 0x95, 0x0F, 0x10 in that order.
- R6: If the byte in a command's terminator position is not 0x20, the only output is 0x15. The next opcode is then parsed as the start of a new command.
- R7: Any other opcode byte, followed by 0x20, produces 0x14, 0x10.
- R8: `in_ready` is 0 whenever `out_valid` is 1. No input byte is consumed while a reply is pending.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` does not change.
- R10: No reply byte is offered while a command is only partly received, however long the gap before its terminator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte is present |
| in_data | input | 8 | Input byte from the receiver |
| in_ready | output | 1 | Block accepts the input byte this cycle |
| out_valid | output | 1 | Reply byte is present |
| out_data | output | 8 | Reply byte to the transmitter |
| out_ready | input | 1 | Transmitter takes the reply byte this cycle |

## Verification
The bench sends a command whose terminator slot holds a wrong byte and expects one 0x15 and no frame. A design that skipped the terminator check would answer 0x14 … 0x10, or would take the next opcode as part of the old command. It also stalls the output side in the middle of a frame. A sequencer that advanced without a handshake would skip signature bytes, or would change `out_data` while the byte is stalled. It holds a sync opcode for many idle cycles before sending the terminator, which catches a design that answers early. It also queries a code missing from the table, which a lookup that defaulted wrongly would answer with stale data instead of 0x00.

// File: rtl/prog_cmd_pkg.sv
package prog_cmd_pkg;
   localparam logic [7:0] OP_SYNC    = 8'h30;
   localparam logic [7:0] OP_GETPAR  = 8'h41;
   localparam logic [7:0] OP_SIGN    = 8'h75;
   localparam logic [7:0] BYTE_EOP   = 8'h20;
   localparam logic [7:0] RSP_INSYNC = 8'h14;
   localparam logic [7:0] RSP_OK     = 8'h10;
   localparam logic [7:0] RSP_NOSYNC = 8'h15;

   typedef enum logic [2:0] {
      RK_SYNC   = 3'd0,
      RK_PARAM  = 3'd1,
      RK_SIGN   = 3'd2,
      RK_OTHER  = 3'd3,
      RK_NOSYNC = 3'd4
   } reply_kind_t;

   typedef enum logic [1:0] {
      PS_OPCODE = 2'd0,
      PS_CODE   = 2'd1,
      PS_EOP    = 2'd2
   } parse_state_t;
endpackage

// File: rtl/prog_param_lookup.sv
module prog_param_lookup #(
   parameter int DATA_W = 8,
   parameter int NUM_PARAMS = 1,
   parameter logic [NUM_PARAMS*DATA_W-1:0] PARAM_CODES = 8'h80,
   parameter logic [NUM_PARAMS*DATA_W-1:0] PARAM_VALS  = 8'h03
) (
   input  logic [DATA_W-1:0] code,
   output logic [DATA_W-1:0] value
);
   generate
      if (NUM_PARAMS < 1) begin : g_bad_count
         $error("prog_param_lookup: NUM_PARAMS must be at least 1");
      end
      if (NUM_PARAMS == 1) begin : g_single
         assign value = (code == PARAM_CODES) ? PARAM_VALS : '0;
      end else begin : g_table
         logic [NUM_PARAMS-1:0] hit;
         for (genvar i = 0; i < NUM_PARAMS; i++) begin : g_cmp
            assign hit[i] = (code == PARAM_CODES[i*DATA_W +: DATA_W]);
         end
         always_comb begin
            value = '0;
            for (int j = NUM_PARAMS - 1; j >= 0; j--) begin
               if (hit[j]) value = PARAM_VALS[j*DATA_W +: DATA_W];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/prog_cmd_parser.sv
module prog_cmd_parser
   import prog_cmd_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   input  logic              busy,
   output logic [DATA_W-1:0] lookup_code,
   input  logic [DATA_W-1:0] lookup_val,
   output logic              start,
   output reply_kind_t       start_kind,
   output logic [DATA_W-1:0] start_val,
   output logic              mid_cmd
);
   parse_state_t        state_q;
   reply_kind_t         kind_q;
   logic [DATA_W-1:0]   val_q;
   logic                accept;

   assign in_ready    = !busy;
   assign accept      = in_valid && in_ready;
   assign lookup_code = in_data;
   assign mid_cmd     = (state_q != PS_OPCODE);
   assign start       = accept && (state_q == PS_EOP);
   assign start_kind  = (in_data == BYTE_EOP) ? kind_q : RK_NOSYNC;
   assign start_val   = val_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= PS_OPCODE;
         kind_q  <= RK_SYNC;
         val_q   <= '0;
      end else if (accept) begin
         unique case (state_q)
            PS_OPCODE: begin
               state_q <= PS_EOP;
               if (in_data == OP_SYNC)        kind_q <= RK_SYNC;
               else if (in_data == OP_SIGN)   kind_q <= RK_SIGN;
               else if (in_data == OP_GETPAR) begin
                  kind_q  <= RK_PARAM;
                  state_q <= PS_CODE;
               end else                       kind_q <= RK_OTHER;
            end
            PS_CODE: begin
               val_q   <= lookup_val;
               state_q <= PS_EOP;
            end
            default: state_q <= PS_OPCODE;
         endcase
      end
   end

   assert_no_accept_busy_R8: assert property (@(posedge clk) disable iff (rst)
      busy |-> !in_ready);
endmodule

// File: rtl/prog_reply_seq.sv
module prog_reply_seq
   import prog_cmd_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter logic [3*DATA_W-1:0] SIGNATURE = 24'h1E950F
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  reply_kind_t       start_kind,
   input  logic [DATA_W-1:0] start_val,
   output logic              busy,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   input  logic              out_ready
);
   localparam int IDX_W = 3;

   reply_kind_t       kind_q;
   logic [DATA_W-1:0] val_q;
   logic [IDX_W-1:0]  idx_q;
   logic [IDX_W-1:0]  last_idx;
   logic              busy_q;

   assign busy      = busy_q;
   assign out_valid = busy_q;

   always_comb begin
      unique case (kind_q)
         RK_PARAM:  last_idx = 3'd2;
         RK_SIGN:   last_idx = 3'd4;
         RK_NOSYNC: last_idx = 3'd0;
         default:   last_idx = 3'd1;
      endcase
   end

   always_comb begin
      out_data = RSP_OK;
      unique case (kind_q)
         RK_NOSYNC: out_data = RSP_NOSYNC;
         RK_PARAM: begin
            if (idx_q == 3'd0)      out_data = RSP_INSYNC;
            else if (idx_q == 3'd1) out_data = val_q;
         end
         RK_SIGN: begin
            if (idx_q == 3'd0) out_data = RSP_INSYNC;
            else if (idx_q <= 3'd3)
               out_data = SIGNATURE[(3 - int'(idx_q))*DATA_W +: DATA_W];
         end
         default: if (idx_q == 3'd0) out_data = RSP_INSYNC;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
         kind_q <= RK_SYNC;
         val_q  <= '0;
      end else if (!busy_q) begin
         if (start) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            kind_q <= start_kind;
            val_q  <= start_val;
         end
      end else if (out_ready) begin
         if (idx_q == last_idx) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
         end else begin
            idx_q <= idx_q + 3'd1;
         end
      end
   end

   assert_hold_stall_R9: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> out_valid && $stable(out_data));
   assert_lead_byte_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(out_valid) |-> (out_data == RSP_INSYNC || out_data == RSP_NOSYNC));
   assert_nosync_alone_R6: assert property (@(posedge clk) disable iff (rst)
      out_valid && out_ready && out_data == RSP_NOSYNC |=> !out_valid);
endmodule

// File: rtl/prog_cmd_responder.sv
module prog_cmd_responder
   import prog_cmd_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int NUM_PARAMS = 1,
   parameter logic [NUM_PARAMS*DATA_W-1:0] PARAM_CODES = 8'h80,
   parameter logic [NUM_PARAMS*DATA_W-1:0] PARAM_VALS  = 8'h03,
   parameter logic [3*DATA_W-1:0] SIGNATURE = 24'h1E950F
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   input  logic              out_ready
);
   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("prog_cmd_responder: DATA_W must be 8");
      end
   endgenerate

   logic              busy;
   logic              start;
   logic              mid_cmd;
   reply_kind_t       start_kind;
   logic [DATA_W-1:0] start_val;
   logic [DATA_W-1:0] lookup_code;
   logic [DATA_W-1:0] lookup_val;

   prog_param_lookup #(
      .DATA_W(DATA_W), .NUM_PARAMS(NUM_PARAMS),
      .PARAM_CODES(PARAM_CODES), .PARAM_VALS(PARAM_VALS)
   ) u_lookup (
      .code(lookup_code), .value(lookup_val)
   );

   prog_cmd_parser #(.DATA_W(DATA_W)) u_parser (
      .clk(clk), .rst(rst),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .busy(busy), .lookup_code(lookup_code), .lookup_val(lookup_val),
      .start(start), .start_kind(start_kind), .start_val(start_val),
      .mid_cmd(mid_cmd)
   );

   prog_reply_seq #(.DATA_W(DATA_W), .SIGNATURE(SIGNATURE)) u_seq (
      .clk(clk), .rst(rst),
      .start(start), .start_kind(start_kind), .start_val(start_val),
      .busy(busy), .out_valid(out_valid), .out_data(out_data),
      .out_ready(out_ready)
   );

   assert_reset_idle_R1: assert property (@(posedge clk)
      rst |=> !out_valid && in_ready);
   assert_no_early_reply_R10: assert property (@(posedge clk) disable iff (rst)
      mid_cmd |-> !out_valid);
   assert_ready_excl_R8: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> !in_ready);
endmodule

// File: tb/prog_cmd_responder_test.sv
module prog_cmd_responder_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       in_valid = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic       in_ready;
   logic       out_valid;
   logic [7:0] out_data;
   logic       out_ready = 1'b1;

   int         n_checks = 0;
   int         n_fails = 0;
   bit         stall_mode = 1'b0;
   bit         finished = 1'b0;
   int         cyc = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #2 clk = ~clk;

   prog_cmd_responder uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
      .out_ready(out_ready)
   );

   task automatic check(input string req, input logic [7:0] act,
                        input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic expect_byte(input logic [7:0] b, input string req);
      exp_q.push_back(b);
      tag_q.push_back(req);
   endtask

   task automatic put_byte(input logic [7:0] b);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = b;
      #1;
      while (!in_ready) begin
         @(negedge clk);
         #1;
      end
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic drain();
      while (exp_q.size() != 0 || out_valid) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   // Monitor: pops the scoreboard on every output handshake.
   logic       prev_stall = 1'b0;
   logic [7:0] prev_data = 8'h00;
   always @(negedge clk) begin
      cyc++;
      out_ready = stall_mode ? (cyc % 3 == 0) : 1'b1;
      #1;
      if (!rst) begin
         if (prev_stall) begin
            check("R9 valid held", {7'd0, out_valid}, 8'h01);
            check("R9 data held", out_data, prev_data);
         end
         if (out_valid && in_ready) check("R8 ready while busy", 8'h01, 8'h00);
         if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
               check("unexpected output byte", out_data, 8'hxx);
            end else begin
               check(tag_q.pop_front(), out_data, exp_q.pop_front());
            end
         end
         prev_stall = out_valid && !out_ready;
         prev_data  = out_data;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_fails++;
         n_checks++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      #1;
      // R1 reset state
      check("R1 out_valid", {7'd0, out_valid}, 8'h00);
      check("R1 in_ready", {7'd0, in_ready}, 8'h01);

      // R2 sync
      expect_byte(8'h14, "R2"); expect_byte(8'h10, "R2");
      put_byte(8'h30); put_byte(8'h20);
      drain();
      // R2 three syncs back to back
      for (int k = 0; k < 3; k++) begin
         expect_byte(8'h14, "R2 repeat"); expect_byte(8'h10, "R2 repeat");
      end
      for (int k = 0; k < 3; k++) begin
         put_byte(8'h30); put_byte(8'h20);
      end
      drain();

      // R3 get-parameter 0x80 -> 0x03
      expect_byte(8'h14, "R3"); expect_byte(8'h03, "R3"); expect_byte(8'h10, "R3");
      put_byte(8'h41); put_byte(8'h80); put_byte(8'h20);
      drain();

      // R4 unsupported code -> 0x00
      expect_byte(8'h14, "R4"); expect_byte(8'h00, "R4"); expect_byte(8'h10, "R4");
      put_byte(8'h41); put_byte(8'h55); put_byte(8'h20);
      drain();

      // R5 signature
      expect_byte(8'h14, "R5"); expect_byte(8'h1E, "R5"); expect_byte(8'h95, "R5");
      expect_byte(8'h0F, "R5"); expect_byte(8'h10, "R5");
      put_byte(8'h75); put_byte(8'h20);
      drain();

      // R6 bad terminator, then recovery
      expect_byte(8'h15, "R6 sync bad eop");
      put_byte(8'h30); put_byte(8'h21);
      drain();
      expect_byte(8'h14, "R6 recover"); expect_byte(8'h10, "R6 recover");
      put_byte(8'h30); put_byte(8'h20);
      drain();
      expect_byte(8'h15, "R6 param bad eop");
      put_byte(8'h41); put_byte(8'h80); put_byte(8'h33);
      drain();

      // R7 unknown opcode
      expect_byte(8'h14, "R7"); expect_byte(8'h10, "R7");
      put_byte(8'h50); put_byte(8'h20);
      drain();

      // R10 long gap before terminator
      put_byte(8'h30);
      for (int k = 0; k < 12; k++) begin
         @(negedge clk); #1;
         check("R10 no early reply", {7'd0, out_valid}, 8'h00);
      end
      expect_byte(8'h14, "R10"); expect_byte(8'h10, "R10");
      put_byte(8'h20);
      drain();

      // R9 backpressure mid-frame
      stall_mode = 1'b1;
      expect_byte(8'h14, "R9 sig"); expect_byte(8'h1E, "R9 sig"); expect_byte(8'h95, "R9 sig");
      expect_byte(8'h0F, "R9 sig"); expect_byte(8'h10, "R9 sig");
      put_byte(8'h75); put_byte(8'h20);
      expect_byte(8'h14, "R9 param"); expect_byte(8'h03, "R9 param"); expect_byte(8'h10, "R9 param");
      put_byte(8'h41); put_byte(8'h80); put_byte(8'h20);
      drain();
      stall_mode = 1'b0;
      repeat (4) @(negedge clk);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end
endmodule